// File: doc/BRIEF.md
# Serial Control Port Register File

This block is a four-wire serial slave through which a host controller reads and writes a small bank of 4-bit configuration and status registers. A host frame is framed by an active-low select line. While select is low, the host clocks in one direction flag, then a 3-bit register address, then a 4-bit payload. On a write, the payload comes from the serial input and lands in the addressed register. On a read, the addressed nibble is shifted out on a serial output that is driven only while read data is valid. The block keeps six writable registers and shows their contents to the rest of the chip as parallel buses. A seventh address returns a 4-bit status nibble that the chip supplies; the host can read it but cannot write it.

The serial pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected on the system clock, so the serial clock has to run well below the system clock. A state machine tracks the frame. Its states are ST_IDLE (no frame open), ST_HDR (collecting flag and address), ST_WDATA (collecting write payload), ST_RDATA (driving read payload), ST_RHOLD (last read bit held until select rises) and ST_WAIT (write done, ignoring further edges). Transitions: IDLE→HDR when select is low. HDR→WDATA or HDR→RDATA on the fourth header rising edge, chosen by the flag. WDATA→WAIT on the fourth payload rising edge, which commits the write. RDATA→RHOLD on the fourth falling edge. Any state→IDLE whenever select is high. The function-mode register (address 2) carries codes the chip decodes: 0000 FSK, 0001 FSK loopback, 0010 call-progress detect, 0011 answer tone, 0100 DTMF send, 0101 single tone, 0110 power-down with oscillator running, 0111 full power-down, 1000 DTMF receive, 1001 DTMF loopback.

Top module: `scp_regfile`

## Requirements
- R1: After reset, all six register outputs read 0000 and the serial output enable is low.
- R2: A frame of flag 0, address A (3 bits, MSB first) and data D (4 bits, MSB first), all sampled on serial clock rising edges, stores D in register A (addresses 0 to 5) and shows it on that register's output bus.
- R3: Serial clock and data activity while select is high changes no register.
- R4: A frame of flag 1 and address A drives the register's nibble on the serial output MSB first. The first bit appears at the first falling edge after the fourth header rising edge, and each later bit appears at the next falling edge.
- R5: The serial output enable stays low through every header and write phase and while no frame is open.
- R6: Raising select at any point ends the frame. The output enable goes low, and a write that has not received all four payload bits is dropped.
- R7: Address 6 reads the status input; a write to address 6 changes nothing.
- R8: Bit 0 of register 0 always reads 0 and its output is always 0, whatever is written.
- R9: Address 7 reads 0000, and a write to it changes no register.
- R10: A register changes only after the fourth payload bit has been sampled; after three payload bits it still holds its old value.
- R11: The serial data input is ignored during the read payload phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scp_clk_i | input | 1 | Serial clock from the host |
| scp_sel_n_i | input | 1 | Active-low frame select |
| scp_sdi_i | input | 1 | Serial data from the host |
| rx_status_i | input | 4 | Status nibble readable at address 6 |
| scp_sdo_o | output | 1 | Serial read data |
| scp_sdo_oe_o | output | 1 | Drive enable for the serial read data pad |
| modem_ctl_o | output | 4 | Register 0: modem/channel/transmit control, bit 0 unused |
| cd_time_o | output | 4 | Register 1: detect timing selects |
| func_mode_o | output | 4 | Register 2: function mode code |
| rx_cfg_o | output | 4 | Register 3: receive gain range, detect level, test |
| tx_atten_o | output | 4 | Register 4: transmit attenuation in 1 dB steps |
| tone_code_o | output | 4 | Register 5: tone code |

## Verification
The bench uses the default parameters: a 4-bit payload, a 3-bit address, two synchronizer stages, and six writable registers plus one status address. This lets every address be written and read back, including the status slot and the unused address 7. Each serial clock half-period lasts ten system clocks, which covers the synchronizer latency. Output bits can therefore be sampled just before each host edge, and frames can be cut short at each payload position.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int DATA_W      = 4;
    localparam int ADDR_W      = 3;
    localparam int NUM_RW      = 6;
    localparam int STATUS_ADDR = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HDR   = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_RHOLD = 3'd4,
        ST_WAIT  = 3'd5
    } scp_state_e;

    // Codes held in the function-mode register
    typedef enum logic [3:0] {
        FM_FSK        = 4'h0,
        FM_FSK_LOOP   = 4'h1,
        FM_CPT_DET    = 4'h2,
        FM_ANS_TONE   = 4'h3,
        FM_DTMF_TX    = 4'h4,
        FM_SINGLE     = 4'h5,
        FM_PWRDN_OSC  = 4'h6,
        FM_PWRDN_FULL = 4'h7,
        FM_DTMF_RX    = 4'h8,
        FM_DTMF_LOOP  = 4'h9
    } func_mode_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RESET_VAL;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/scp_serial_fsm.sv
module scp_serial_fsm
    import scp_pkg::*;
#(
    parameter int DW = 4,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sel_n_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sclk_rise,
    output logic          sclk_fall
);

    localparam int HDR_BITS = 1 + AW;
    localparam int MAX_BITS = (HDR_BITS > DW) ? HDR_BITS : DW;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    scp_state_e          state, nxt;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_BITS-1:0] hdr_sr, hdr_next;
    logic [DW-1:0]       dat_sr, rd_snap;
    logic                sclk_d;
    logic                hdr_last, dat_last, rd_last;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign hdr_next  = {hdr_sr[HDR_BITS-2:0], sdi_s};
    assign rd_addr   = hdr_next[AW-1:0];
    assign hdr_last  = (cnt == CNT_W'(HDR_BITS - 1));
    assign dat_last  = (cnt == CNT_W'(DW - 1));
    assign rd_last   = dat_last;

    // next-state decision
    always_comb begin
        nxt = state;
        if (sel_n_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_HDR;
                ST_HDR:   if (sclk_rise && hdr_last)
                              nxt = hdr_next[HDR_BITS-1] ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (sclk_rise && dat_last) nxt = ST_WAIT;
                ST_RDATA: if (sclk_fall && rd_last)  nxt = ST_RHOLD;
                ST_RHOLD: nxt = ST_RHOLD;
                ST_WAIT:  nxt = ST_WAIT;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register with shift and count state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            hdr_sr  <= '0;
            dat_sr  <= '0;
            rd_snap <= '0;
            sclk_d  <= 1'b0;
        end else begin
            state  <= nxt;
            sclk_d <= sclk_s;

            if (nxt != state)
                cnt <= '0;
            else if (((state == ST_HDR) || (state == ST_WDATA)) && sclk_rise)
                cnt <= cnt + 1'b1;
            else if ((state == ST_RDATA) && sclk_fall)
                cnt <= cnt + 1'b1;

            if (state == ST_IDLE)
                hdr_sr <= '0;
            else if ((state == ST_HDR) && sclk_rise && !sel_n_s)
                hdr_sr <= hdr_next;

            if (state == ST_IDLE)
                dat_sr <= '0;
            else if ((state == ST_WDATA) && sclk_rise && !sel_n_s)
                dat_sr <= {dat_sr[DW-2:0], sdi_s};

            if ((state == ST_HDR) && (nxt == ST_RDATA))
                rd_snap <= rd_data;
            else if ((state == ST_RDATA) && sclk_fall && !sel_n_s)
                rd_snap <= {rd_snap[DW-2:0], 1'b0};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            if ((nxt != ST_RDATA) && (nxt != ST_RHOLD))
                sdo_oe <= 1'b0;
            else if ((state == ST_RDATA) && sclk_fall)
                sdo_oe <= 1'b1;

            if ((state == ST_RDATA) && sclk_fall && !sel_n_s)
                sdo <= rd_snap[DW-1];

            wr_en <= (state == ST_WDATA) && sclk_rise && dat_last && !sel_n_s;
            if ((state == ST_WDATA) && sclk_rise && dat_last && !sel_n_s) begin
                wr_addr <= hdr_sr[AW-1:0];
                wr_data <= {dat_sr[DW-2:0], sdi_s};
            end
        end
    end

endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
    parameter int            DW          = 4,
    parameter int            AW          = 3,
    parameter int            NREG        = 6,
    parameter int            STAT_ADDR   = 6,
    parameter logic [DW-1:0] REG0_MASK   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    input  logic [DW-1:0]      status_i,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] MASK = (i == 0) ? REG0_MASK : {DW{1'b1}};
        logic [DW-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_addr == AW'(i)))
                q <= wr_data & MASK;
        end

        assign regs_o[i*DW +: DW] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs_o[i*DW +: DW];
        end
        if (rd_addr == AW'(STAT_ADDR)) rd_data = status_i;
    end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int SYNC_N = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scp_clk_i,
    input  logic              scp_sel_n_i,
    input  logic              scp_sdi_i,
    input  logic [DATA_W-1:0] rx_status_i,
    output logic              scp_sdo_o,
    output logic              scp_sdo_oe_o,
    output logic [DATA_W-1:0] modem_ctl_o,
    output logic [DATA_W-1:0] cd_time_o,
    output logic [DATA_W-1:0] func_mode_o,
    output logic [DATA_W-1:0] rx_cfg_o,
    output logic [DATA_W-1:0] tx_atten_o,
    output logic [DATA_W-1:0] tone_code_o
);

    localparam logic [DATA_W-1:0] BR0_MASK = ~DATA_W'(1);

    logic [2:0]               pins_s;
    logic                     sclk_s, sel_n_s, sdi_s;
    logic                     sclk_rise, sclk_fall;
    logic                     wr_en;
    logic [ADDR_W-1:0]        wr_addr, rd_addr;
    logic [DATA_W-1:0]        wr_data, rd_data;
    logic [NUM_RW*DATA_W-1:0] regs_flat;

    scp_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_N),
        .RESET_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scp_clk_i, scp_sel_n_i, scp_sdi_i}),
        .q     (pins_s)
    );

    assign {sclk_s, sel_n_s, sdi_s} = pins_s;

    scp_serial_fsm #(
        .DW (DATA_W),
        .AW (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sel_n_s   (sel_n_s),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (scp_sdo_o),
        .sdo_oe    (scp_sdo_oe_o),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    scp_regbank #(
        .DW        (DATA_W),
        .AW        (ADDR_W),
        .NREG      (NUM_RW),
        .STAT_ADDR (STATUS_ADDR),
        .REG0_MASK (BR0_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status_i (rx_status_i),
        .rd_data  (rd_data),
        .regs_o   (regs_flat)
    );

    assign modem_ctl_o = regs_flat[0*DATA_W +: DATA_W];
    assign cd_time_o   = regs_flat[1*DATA_W +: DATA_W];
    assign func_mode_o = regs_flat[2*DATA_W +: DATA_W];
    assign rx_cfg_o    = regs_flat[3*DATA_W +: DATA_W];
    assign tx_atten_o  = regs_flat[4*DATA_W +: DATA_W];
    assign tone_code_o = regs_flat[5*DATA_W +: DATA_W];

endmodule

// File: rtl/scp_regfile_chk.sv
module scp_regfile_chk
    import scp_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_n_s,
    input logic                     sclk_fall,
    input logic                     wr_en,
    input logic                     scp_sdo_o,
    input logic                     scp_sdo_oe_o,
    input logic [DATA_W-1:0]        modem_ctl_o,
    input logic [NUM_RW*DATA_W-1:0] regs_flat
);

    AST_ABORT_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !scp_sdo_oe_o);  // R6

    AST_NO_DRIVE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scp_sdo_oe_o);  // R5

    AST_REGS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));  // R10

    AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (scp_sdo_oe_o && !sclk_fall) |=> $stable(scp_sdo_o));  // R4

    AST_REG0_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !modem_ctl_o[0]);  // R8

endmodule

bind scp_regfile scp_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n_s      (sel_n_s),
    .sclk_fall    (sclk_fall),
    .wr_en        (wr_en),
    .scp_sdo_o    (scp_sdo_o),
    .scp_sdo_oe_o (scp_sdo_oe_o),
    .modem_ctl_o  (modem_ctl_o),
    .regs_flat    (regs_flat)
);

// File: tb/test_scp_regfile.sv
module test_scp_regfile;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic       sdi = 1'b0;
    logic [3:0] status = 4'h0;
    logic       sdo, sdo_oe;
    logic [3:0] r0, r1, r2, r3, r4, r5;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  oe_seen = 0;
    logic [3:0] exp_r [6];

    always #10 clk = ~clk;

    scp_regfile i_scp_regfile (
        .clk          (clk),
        .rst_n        (rst_n),
        .scp_clk_i    (sclk),
        .scp_sel_n_i  (sel_n),
        .scp_sdi_i    (sdi),
        .rx_status_i  (status),
        .scp_sdo_o    (sdo),
        .scp_sdo_oe_o (sdo_oe),
        .modem_ctl_o  (r0),
        .cd_time_o    (r1),
        .func_mode_o  (r2),
        .rx_cfg_o     (r3),
        .tx_atten_o   (r4),
        .tone_code_o  (r5)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " reg0"}, r0, exp_r[0]);
        chk({tag, " reg1"}, r1, exp_r[1]);
        chk({tag, " reg2"}, r2, exp_r[2]);
        chk({tag, " reg3"}, r3, exp_r[3]);
        chk({tag, " reg4"}, r4, exp_r[4]);
        chk({tag, " reg5"}, r5, exp_r[5]);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_n(H);
        if (sdo_oe) oe_seen = 1;
        sclk = 1'b1;
        wait_n(H);
        sclk = 1'b0;
    endtask

    task automatic open_frame();
        sel_n = 1'b0;
        wait_n(H);
    endtask

    task automatic close_frame();
        wait_n(H);
        sel_n = 1'b1;
        wait_n(H);
    endtask

    task automatic send_hdr(input logic rw, input logic [2:0] a);
        send_bit(rw);
        for (int i = 2; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [3:0] d);
        open_frame();
        send_hdr(1'b0, a);
        for (int i = 3; i >= 0; i--) send_bit(d[i]);
        close_frame();
    endtask

    // R4 R11: read with sdi toggled during payload phase
    task automatic do_read(input logic [2:0] a, output logic [3:0] d);
        open_frame();
        send_hdr(1'b1, a);
        for (int k = 0; k < 4; k++) begin
            wait_n(H);
            chk("R4 output enable during read bit", {3'b0, sdo_oe}, 4'b0001);
            d[3-k] = sdo;
            sdi = ~sdi;
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
        end
        wait_n(H);
        chk("R4 enable held after last bit", {3'b0, sdo_oe}, 4'b0001);
        sel_n = 1'b1;
        wait_n(6);
        chk("R6 enable released after select rises", {3'b0, sdo_oe}, 4'b0000);
        wait_n(H);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) exp_r[i] = 4'h0;
        chk_regs("R1 reset");
        chk("R1 enable at reset", {3'b0, sdo_oe}, 4'b0000);
    endtask

    task automatic t_write_read();
        logic [3:0] pat [6];
        logic [3:0] got;
        pat[0] = 4'b1011; pat[1] = 4'b0110; pat[2] = 4'b1001;
        pat[3] = 4'b0101; pat[4] = 4'b1111; pat[5] = 4'b1100;
        for (int i = 0; i < 6; i++) begin
            do_write(3'(i), pat[i]);
            exp_r[i] = (i == 0) ? (pat[i] & 4'b1110) : pat[i];
        end
        chk_regs("R2 write all");
        chk("R8 reg0 bit0 output", {3'b0, r0[0]}, 4'b0000);
        for (int i = 0; i < 6; i++) begin
            do_read(3'(i), got);
            chk((i == 0) ? "R8 read reg0" : "R4 read back", got, exp_r[i]);
        end
        chk_regs("R11 regs after reads with toggling input");
    endtask

    task automatic t_no_drive_on_write();
        oe_seen = 0;
        do_write(3'd4, 4'b0011);
        exp_r[4] = 4'b0011;
        chk("R5 enable during write", {3'b0, oe_seen}, 4'b0000);
        chk("R2 second pattern", r4, 4'b0011);
    endtask

    task automatic t_sel_high();
        sel_n = 1'b1;
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        wait_n(H);
        chk_regs("R3 edges with select high");
        chk("R5 idle enable", {3'b0, sdo_oe}, 4'b0000);
    endtask

    task automatic t_partial_and_abort();
        open_frame();
        send_hdr(1'b0, 3'd5);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        wait_n(H);
        chk("R10 after three payload bits", r5, exp_r[5]);
        send_bit(1'b1);
        wait_n(H);
        exp_r[5] = 4'b0011;
        chk("R10 after fourth payload bit", r5, exp_r[5]);
        close_frame();

        open_frame();
        send_hdr(1'b0, 3'd1);
        send_bit(1'b1); send_bit(1'b1);
        sel_n = 1'b1;
        wait_n(H);
        chk("R6 aborted write", r1, exp_r[1]);

        open_frame();
        send_hdr(1'b1, 3'd2);
        wait_n(H);
        sclk = 1'b1; wait_n(H); sclk = 1'b0;
        wait_n(H);
        chk("R4 enable at first read bit", {3'b0, sdo_oe}, 4'b0001);
        sel_n = 1'b1;
        wait_n(6);
        chk("R6 read abort releases line", {3'b0, sdo_oe}, 4'b0000);
        wait_n(H);
        chk_regs("R6 regs after aborts");
    endtask

    task automatic t_status();
        logic [3:0] got;
        status = 4'b1010;
        do_read(3'd6, got);
        chk("R7 status read", got, 4'b1010);
        do_write(3'd6, 4'b0101);
        chk_regs("R7 write to status address");
        status = 4'b0110;
        do_read(3'd6, got);
        chk("R7 status follows input", got, 4'b0110);
    endtask

    task automatic t_addr7();
        logic [3:0] got;
        do_write(3'd7, 4'b1111);
        chk_regs("R9 write to address 7");
        do_read(3'd7, got);
        chk("R9 read address 7", got, 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_write_read();
        t_no_drive_on_write();
        t_sel_high();
        t_partial_and_abort();
        t_status();
        t_addr7();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule